// File: doc/BRIEF.md
# Sequential-Address Flash Program Sequencer

This block is the host-side engine that burns a run of consecutive bytes into a serial NOR flash. The flash uses a program mode in which it advances its own address after each byte. The caller gives a start address and a byte count with a one-cycle `start` pulse. The data then arrives one byte at a time over a valid/ready handshake. The sequencer drives chip select, a divided serial clock and the data-out line in SPI mode 0, and it samples the data-in line. It ends the run with a one-cycle `done` pulse, and `error` is raised in the same cycle if the run failed.

A run has a fixed shape. First comes a write-enable frame. Next comes a program frame that carries the opcode, the 24-bit address and the first byte. Each later byte travels in its own short frame that holds only the opcode and the data. After every program frame the sequencer reads the status register until the busy flag clears. After the last byte it sends write-disable and polls status one final time.

Chip select stays high for a minimum number of system clocks between frames. The sequencer refuses any run that would cross the highest programmable address, because the flash does not wrap. It also stops with an error if the write-enable latch has dropped after the first byte.

Top module: `flash_burst_prog`

## Requirements
- R1: When `start` is sampled while idle with `byte_count` = 0, `done` is 1 and `error` is 0 in the next cycle, and chip select never falls.
- R2: When `start_addr + byte_count - 1` exceeds `ADDR_LIMIT`, `done` and `error` are both 1 in the cycle after `start`, and chip select never falls.
- R3: The first frame of every accepted run is exactly one byte, the write-enable opcode 06h.
- R4: The second frame is exactly five bytes. It holds opcode AFh, then address bits 23..16, 15..8 and 7..0, then the first data byte. Every byte is sent bit 7 first.
- R5: Each data byte after the first is sent in its own two-byte frame of opcode AFh followed by that byte. Bytes go out in the order they were accepted.
- R6: Each program frame is followed by a status frame. The status frame starts with opcode 05h and continues reading one status byte at a time while status bit 0 (busy) is 1. It ends right after the first byte that has bit 0 = 0.
- R7: After the status frame that follows the last byte, the sequencer sends a one-byte frame with opcode 04h. A final status frame of the R6 form comes next, and then `done` pulses with `error` = 0.
- R8: If the status byte that ends the poll after the second frame has bit 1 (write-enable latch) = 0, the sequencer pulses `done` with `error` = 1 and starts no further frame.
- R9: Chip select stays high for at least `CS_GAP` system clocks between any two frames.
- R10: SCK is low whenever chip select is high. MOSI changes only while SCK is low. MISO is sampled on the rising SCK edge.
- R11: `in_ready` is 1 only while chip select is high and a data byte is awaited. A run accepts exactly `byte_count` bytes, or one byte when R8 ends it.
- R12: `error` is 1 only in a cycle where `done` is 1, and `done` pulses exactly once per `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| start_addr | input | ADDR_W | Flash address of the first byte |
| byte_count | input | CNT_W | Number of bytes to program |
| in_data | input | 8 | Next data byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Sequencer takes the byte this cycle |
| active | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run failed; only together with `done` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a run in which the flash drops its write-enable latch right after the first byte. A well-behaved flash never does this. The bench flash model has a switch that clears its latch at the end of the first program frame, and one directed run uses it. The busy time of every status poll is drawn at random from zero to three status bytes. This gives each poll frame a different length and shows that the poll loop follows the busy bit rather than a fixed count. Runs that end exactly on the highest address, and runs that pass it by one byte, are placed directly.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam int ADDR_BITS = 24;

  localparam logic [7:0] OP_WR_EN   = 8'h06;
  localparam logic [7:0] OP_WR_DIS  = 8'h04;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_SEQ_PGM = 8'hAF;
  localparam logic [7:0] OP_FILL    = 8'h00;

  localparam int ST_BUSY = 0;
  localparam int ST_LATCH = 1;

  typedef enum logic [2:0] {
    FK_WEN, FK_HEAD, FK_TAIL, FK_POLL, FK_WDIS, FK_LAST
  } frame_kind_t;

  typedef enum logic [2:0] {
    CS_IDLE, CS_GAP, CS_LOAD, CS_ISSUE, CS_SEND
  } ctrl_state_t;

  function automatic logic kind_is_poll(frame_kind_t k);
    return (k == FK_POLL) || (k == FK_LAST);
  endfunction

  function automatic logic kind_needs_data(frame_kind_t k);
    return (k == FK_HEAD) || (k == FK_TAIL);
  endfunction

  // index of the final byte of a fixed-length frame
  function automatic logic [2:0] frame_last(frame_kind_t k);
    case (k)
      FK_HEAD: return 3'd4;
      FK_TAIL: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] frame_byte(frame_kind_t k, logic [2:0] idx,
                                            logic [ADDR_BITS-1:0] a, logic [7:0] d);
    logic [7:0] b;
    b = OP_FILL;
    case (k)
      FK_WEN:  b = OP_WR_EN;
      FK_WDIS: b = OP_WR_DIS;
      FK_POLL, FK_LAST: b = (idx == 3'd0) ? OP_STATUS : OP_FILL;
      FK_HEAD: begin
        case (idx)
          3'd0: b = OP_SEQ_PGM;
          3'd1: b = a[23:16];
          3'd2: b = a[15:8];
          3'd3: b = a[7:0];
          default: b = d;
        endcase
      end
      FK_TAIL: b = (idx == 3'd0) ? OP_SEQ_PGM : d;
      default: b = OP_FILL;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/fbp_spi_byte.sv
module fbp_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       fin,
  output logic       busy
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_TOP = DW'(HALF_DIV - 1);

  logic          run_q, sck_q, mosi_q, fin_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_tx, sh_rx;

  wire half_tick = run_q && (div_q == DIV_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; sck_q <= 1'b0; mosi_q <= 1'b0; fin_q <= 1'b0;
      div_q <= '0; bit_q <= '0; sh_tx <= '0; sh_rx <= '0;
    end else begin
      fin_q <= 1'b0;
      if (!run_q) begin
        if (go) begin
          run_q  <= 1'b1;
          sh_tx  <= tx;
          mosi_q <= tx[7];
          bit_q  <= '0;
          div_q  <= '0;
          sck_q  <= 1'b0;
        end
      end else if (half_tick) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            run_q <= 1'b0;
            fin_q <= 1'b1;
          end else begin
            bit_q  <= bit_q + 3'd1;
            sh_tx  <= {sh_tx[6:0], 1'b0};
            mosi_q <= sh_tx[6];
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = mosi_q;
  assign rx   = sh_rx;
  assign fin  = fin_q;
  assign busy = run_q;
endmodule

// File: rtl/fbp_gap_timer.sv
module fbp_gap_timer #(
  parameter int CS_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expired
);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(CS_GAP);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (kick)           cnt_q <= GAP_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0) && !kick;
endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int                ADDR_W     = 24,
  parameter int                CNT_W      = 25,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = 24'h01FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              active,
  output logic              done,
  output logic              error,
  output logic              cs_n,
  output logic              eng_go,
  output logic [7:0]        eng_tx,
  input  logic              eng_fin,
  input  logic [7:0]        eng_rx,
  output logic              gap_kick,
  input  logic              gap_done
);
  localparam int SW = (ADDR_W > CNT_W ? ADDR_W : CNT_W) + 2;

  // true when the last byte of the run lies at or below the limit
  function automatic logic span_ok(logic [ADDR_W-1:0] a, logic [CNT_W-1:0] n);
    logic [SW-1:0] end_excl, lim_excl;
    end_excl = SW'(a) + SW'(n);
    lim_excl = SW'(ADDR_LIMIT) + SW'(1);
    return end_excl <= lim_excl;
  endfunction

  ctrl_state_t       state;
  frame_kind_t       kind, nxt;
  logic [2:0]        idx;
  logic              cs_q, go_q, done_q, err_q, kick_q, head_poll;
  logic [7:0]        tx_q, data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  remain_q;

  logic frame_more;
  logic [2:0] idx_next;

  always_comb begin
    if (kind_is_poll(kind)) begin
      frame_more = (idx == 3'd0) || eng_rx[ST_BUSY];
      idx_next   = 3'd1;
    end else begin
      frame_more = (idx != frame_last(kind));
      idx_next   = idx + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CS_IDLE; kind <= FK_WEN; nxt <= FK_WEN; idx <= '0;
      cs_q <= 1'b1; go_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      kick_q <= 1'b0; head_poll <= 1'b0;
      tx_q <= '0; data_q <= '0; addr_q <= '0; remain_q <= '0;
    end else begin
      go_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; kick_q <= 1'b0;
      case (state)
        CS_IDLE: if (start) begin
          addr_q   <= start_addr;
          remain_q <= byte_count;
          if (byte_count == '0) begin
            done_q <= 1'b1;
          end else if (!span_ok(start_addr, byte_count)) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            nxt   <= FK_WEN;
            state <= CS_GAP;
          end
        end
        CS_GAP: if (gap_done) begin
          kind  <= nxt;
          state <= kind_needs_data(nxt) ? CS_LOAD : CS_ISSUE;
        end
        CS_LOAD: if (in_valid) begin
          data_q   <= in_data;
          remain_q <= remain_q - 1'b1;
          state    <= CS_ISSUE;
        end
        CS_ISSUE: begin
          cs_q  <= 1'b0;
          go_q  <= 1'b1;
          tx_q  <= frame_byte(kind, 3'd0, addr_q, data_q);
          idx   <= 3'd0;
          state <= CS_SEND;
        end
        CS_SEND: if (eng_fin) begin
          if (frame_more) begin
            idx  <= idx_next;
            go_q <= 1'b1;
            tx_q <= frame_byte(kind, idx_next, addr_q, data_q);
          end else begin
            cs_q   <= 1'b1;
            kick_q <= 1'b1;
            state  <= CS_GAP;
            case (kind)
              FK_WEN:  nxt <= FK_HEAD;
              FK_HEAD: begin nxt <= FK_POLL; head_poll <= 1'b1; end
              FK_TAIL: nxt <= FK_POLL;
              FK_POLL: begin
                head_poll <= 1'b0;
                if (head_poll && !eng_rx[ST_LATCH]) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= CS_IDLE;
                end else begin
                  nxt <= (remain_q == '0) ? FK_WDIS : FK_TAIL;
                end
              end
              FK_WDIS: nxt <= FK_LAST;
              FK_LAST: begin done_q <= 1'b1; state <= CS_IDLE; end
              default: state <= CS_IDLE;
            endcase
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign in_ready = (state == CS_LOAD);
  assign active   = (state != CS_IDLE);
  assign done     = done_q;
  assign error    = err_q;
  assign cs_n     = cs_q;
  assign eng_go   = go_q;
  assign eng_tx   = tx_q;
  assign gap_kick = kick_q;
endmodule

// File: rtl/flash_burst_prog.sv
module flash_burst_prog #(
  parameter int                ADDR_W     = 24,
  parameter int                CNT_W      = ADDR_W + 1,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = 24'h01FFFF,
  parameter int                HALF_DIV   = 2,
  parameter int                CS_GAP     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              active,
  output logic              done,
  output logic              error,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic       eng_go, eng_fin, eng_busy, gap_kick, gap_done;
  logic [7:0] eng_tx, eng_rx;

  fbp_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADDR_LIMIT(ADDR_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .active(active), .done(done), .error(error),
    .cs_n(spi_cs_n), .eng_go(eng_go), .eng_tx(eng_tx), .eng_fin(eng_fin),
    .eng_rx(eng_rx), .gap_kick(gap_kick), .gap_done(gap_done)
  );

  fbp_spi_byte #(.HALF_DIV(HALF_DIV)) u_byte (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .rx(eng_rx), .fin(eng_fin), .busy(eng_busy)
  );

  fbp_gap_timer #(.CS_GAP(CS_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .kick(gap_kick), .expired(gap_done)
  );
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
  parameter int                ADDR_W     = 24,
  parameter int                CNT_W      = 25,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = 24'h01FFFF,
  parameter int                CS_GAP     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [CNT_W-1:0]  byte_count,
  input logic              in_ready,
  input logic              active,
  input logic              done,
  input logic              error,
  input logic              spi_cs_n,
  input logic              spi_sck,
  input logic              spi_mosi
);
  localparam int HW = $clog2(CS_GAP + 2) + 1;
  localparam logic [HW-1:0] HSAT = HW'(CS_GAP);

  logic [HW-1:0] high_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          high_run <= HSAT;
    else if (!spi_cs_n)  high_run <= '0;
    else if (high_run < HSAT) high_run <= high_run + 1'b1;
  end

  wire past_limit = (longint'(start_addr) + longint'(byte_count) - 64'sd1) > longint'(ADDR_LIMIT);

  a_r1_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active && byte_count == '0) |=> (done && !error));

  a_r2_span_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active && byte_count != '0 && past_limit) |=> (done && error && spi_cs_n));

  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (high_run >= HSAT));

  a_r10_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r10_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  a_r11_ready_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (spi_cs_n && active));

  a_r12_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
endmodule

bind flash_burst_prog fbp_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADDR_LIMIT(ADDR_LIMIT), .CS_GAP(CS_GAP)
) u_fbp_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
  .byte_count(byte_count), .in_ready(in_ready), .active(active), .done(done),
  .error(error), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/flash_burst_prog_test.sv
module flash_burst_prog_test;
  localparam int ADDR_W = 24;
  localparam int CNT_W = 25;
  localparam logic [ADDR_W-1:0] LIMIT = 24'h01FFFF;
  localparam int CS_GAP = 4;
  localparam int FMAX = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, spi_miso = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [7:0] in_data = '0;
  logic in_ready, active, done, error, spi_cs_n, spi_sck, spi_mosi;

  always #2.5 clk = ~clk;

  flash_burst_prog #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADDR_LIMIT(LIMIT),
                     .HALF_DIV(2), .CS_GAP(CS_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .active(active), .done(done), .error(error),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] fb [FMAX][8];
  int flen [FMAX];
  int fnb [FMAX];
  int nfrm = 0, bits = 0, cur_nb = 0, ragged = 0;
  logic [7:0] shin = '0;
  bit wel = 1'b0, wel_bad = 1'b0;

  function automatic logic [7:0] status_byte(int k);
    return {6'b0, wel, (k < cur_nb)};
  endfunction

  always @(negedge spi_cs_n) begin
    bits = 0;
    cur_nb = $urandom % 4;
  end

  always @(posedge spi_cs_n) begin
    if (nfrm < FMAX) begin
      flen[nfrm] = bits / 8;
      fnb[nfrm] = cur_nb;
      if (bits % 8 != 0) ragged++;
      if (bits >= 8 && fb[nfrm][0] == 8'h06) wel = 1'b1;
      if (bits >= 8 && fb[nfrm][0] == 8'h04) wel = 1'b0;
      if (bits == 40 && wel_bad) wel = 1'b0;
      nfrm++;
    end
  end

  always @(posedge spi_sck) if (!spi_cs_n && nfrm < FMAX) begin
    shin = {shin[6:0], spi_mosi};
    bits++;
    if (bits % 8 == 0 && bits <= 64) fb[nfrm][bits/8 - 1] = shin;
  end

  always @(negedge spi_sck) if (!spi_cs_n && nfrm < FMAX && bits >= 8 && fb[nfrm][0] == 8'h05) begin
    logic [7:0] st;
    st = status_byte((bits - 8) / 8);
    spi_miso = st[7 - ((bits - 8) % 8)];
  end

  // ---------------- port monitors ----------------
  int done_cnt = 0, viol_sck = 0, viol_mosi = 0, hc = 0, gap_min = 1000;
  bit first_fall = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
  int cycles = 0;

  always @(negedge clk) if (done) done_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (spi_cs_n && spi_sck) viol_sck++;
    if (spi_sck && prev_sck && spi_mosi != prev_mosi) viol_mosi++;
    if (spi_cs_n) hc++;
    else begin
      if (prev_cs) begin
        if (!first_fall && hc < gap_min) gap_min = hc;
        first_fall = 1'b0;
      end
      hc = 0;
    end
    prev_sck = spi_sck; prev_mosi = spi_mosi; prev_cs = spi_cs_n;
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    failures++; checks++;
    $display("FAIL R12 watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  logic [7:0] dat [64];
  int accepted = 0;
  bit stop = 1'b0, got_err = 1'b0, done_first = 1'b0;

  task automatic feeder(input int n);
    for (int i = 0; i < n && !stop; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = dat[i];
      while (!in_ready && !stop) @(negedge clk);
      if (stop) begin in_valid = 1'b0; break; end
      @(posedge clk);
      accepted++;
      #1 in_valid = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic waiter();
    int t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
    got_err = error;
    if (!done) check(1'b0, "R12", "done never seen", 0, 1);
    stop = 1'b1;
  endtask

  function automatic int exp_frames(int n, bit bad);
    if (n == 0) return 0;
    if (bad) return 3;
    return 2 * n + 3;
  endfunction

  function automatic bit refused(logic [ADDR_W-1:0] a, int n);
    return n != 0 && (longint'(a) + n - 1 > longint'(LIMIT));
  endfunction

  task automatic verify(input logic [ADDR_W-1:0] a, input int n, input bit bad);
    int e3 = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0;
    bool_frames: begin end
    // R3 write-enable frame
    if (nfrm > 0 && !(flen[0] == 1 && fb[0][0] == 8'h06)) e3++;
    // R4 head frame
    if (nfrm > 1 && !(flen[1] == 5 && fb[1][0] == 8'hAF && fb[1][1] == a[23:16] &&
                      fb[1][2] == a[15:8] && fb[1][3] == a[7:0] && fb[1][4] == dat[0])) e4++;
    // R6 polls after each program frame
    for (int k = 0; k < (bad ? 1 : n); k++) begin
      int f = 2 + 2 * k;
      if (f < nfrm && !(fb[f][0] == 8'h05 && flen[f] == fnb[f] + 2)) e6++;
    end
    // R5 tail frames
    if (!bad) for (int k = 1; k < n; k++) begin
      int f = 1 + 2 * k;
      if (f < nfrm && !(flen[f] == 2 && fb[f][0] == 8'hAF && fb[f][1] == dat[k])) e5++;
    end
    // R7 closing frames
    if (!bad && n > 0) begin
      int f = 2 * n + 1;
      if (f + 1 < nfrm + 1 && f < nfrm) begin
        if (!(flen[f] == 1 && fb[f][0] == 8'h04)) e7++;
        if (f + 1 < nfrm && !(fb[f+1][0] == 8'h05 && flen[f+1] == fnb[f+1] + 2)) e7++;
      end else e7++;
    end
    check(nfrm == exp_frames(n, bad), bad ? "R8" : "R7", "frame count", nfrm, exp_frames(n, bad));
    check(e3 == 0, "R3", "write-enable frame mismatches", e3, 0);
    check(e4 == 0, "R4", "head frame mismatches", e4, 0);
    check(e6 == 0, "R6", "status poll mismatches", e6, 0);
    if (!bad) check(e5 == 0, "R5", "tail frame mismatches", e5, 0);
    if (!bad) check(e7 == 0, "R7", "closing frame mismatches", e7, 0);
  endtask

  task automatic run_case(input logic [ADDR_W-1:0] a, input int n, input bit bad);
    bit is_ref;
    is_ref = refused(a, n);
    for (int i = 0; i < 64; i++) dat[i] = 8'($urandom);
    nfrm = 0; done_cnt = 0; accepted = 0; stop = 1'b0; got_err = 1'b0;
    wel_bad = bad; wel = 1'b0; gap_min = 1000; first_fall = 1'b1;
    viol_sck = 0; viol_mosi = 0; ragged = 0;
    @(negedge clk);
    start = 1'b1; start_addr = a; byte_count = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    done_first = done;
    fork
      feeder(is_ref ? 0 : n);
      waiter();
    join
    repeat (20) @(negedge clk);
    if (n == 0) begin
      check(done_first && !got_err, "R1", "zero count done/error", {done_first, got_err}, 2);
      check(nfrm == 0, "R1", "frames on zero count", nfrm, 0);
    end else if (is_ref) begin
      check(done_first && got_err, "R2", "span refusal done/error", {done_first, got_err}, 3);
      check(nfrm == 0, "R2", "frames on refused span", nfrm, 0);
    end else begin
      verify(a, n, bad);
      check(got_err == bad, bad ? "R8" : "R7", "error flag", got_err, bad);
      check(accepted == (bad ? 1 : n), "R11", "bytes accepted", accepted, bad ? 1 : n);
      check(gap_min >= CS_GAP, "R9", "shortest chip-select high time", gap_min, CS_GAP);
      check(viol_sck == 0 && viol_mosi == 0 && ragged == 0, "R10", "mode 0 violations",
            viol_sck + viol_mosi + ragged, 0);
    end
    check(done_cnt == 1, "R12", "done pulses per start", done_cnt, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0F1A));
    repeat (4) @(negedge clk);
    check(spi_cs_n && !spi_sck && !done && !error && !in_ready && !active,
          "R10", "reset state", {spi_cs_n, spi_sck, done, error}, 8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_case(24'h000100, 0, 1'b0);            // R1
    run_case(LIMIT, 2, 1'b0);                 // R2 one past the top
    run_case(24'h020000, 1, 1'b0);            // R2 start above the top
    run_case(24'h000000, 1, 1'b0);            // single byte
    run_case(LIMIT - 24'd2, 3, 1'b0);         // ends exactly on the top
    run_case(24'h001234, 5, 1'b1);            // R8 latch lost
    for (int r = 0; r < 6; r++) begin
      int n;
      logic [ADDR_W-1:0] a;
      n = 1 + ($urandom % 12);
      a = ADDR_W'($urandom % 32'h1FF00);
      run_case(a, n, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule